// File: doc/BRIEF.md
# Window Filter Debounce Unit

This unit sits behind a two-channel sampling sequencer. After each scan the sequencer presents one sample per channel and pulses an evaluate strobe. The unit checks both samples against a bank of filter pairs. Each pair holds a window for channel 0 and a window for channel 1. A window is a lower and an upper limit plus a flag. The flag selects whether a hit means the sample is inside the limits or outside them. The pairs that hit in one evaluation form a hit set.

The hit set drives one of two saturating counters. The periodic counter is used while low-power scanning is on and the counter is below its limit; once it reaches that limit, the unit asks the sequencer for continuous scanning. The debounce counter is used otherwise. When the debounce count reaches its threshold, the event is confirmed. The hitting pairs are then set in a sticky status vector, which software clears by writing ones. An interrupt follows from any set status bit. The sample values of the first confirmed event are captured, and each pair that is enabled for wakeup gives a one-cycle wakeup pulse.

Top module: `winflt_debounce`

## Requirements
- R1: A window hits in inside mode (mode bit 0) when lower ≤ sample ≤ upper, both limits inclusive. In outside mode (mode bit 1) it hits when sample < lower or sample > upper.
- R2: A pair hits when at least one of its two channel enables is set and every enabled channel's window hits. A pair with both enables clear never hits. An outside window with limits 0 and all-ones never hits, so it blocks its pair.
- R3: On an evaluation where some pair hits and either the previous hit set was empty or the same set hit again, the selected counter increments. It stops at its limit. A debounce evaluation whose count after update equals the debounce threshold is a confirmed event; this is repeated on every later matching evaluation at threshold.
- R4: An evaluation with an empty hit set, or with a non-empty set that differs from a non-empty previous set, clears the selected counter.
- R5: The periodic counter is selected while low-power mode is enabled and its count is below the periodic limit; otherwise the debounce counter is selected. The continuous-scan request output is high while low-power mode is enabled and the periodic count is at or above the periodic limit.
- R6: When the debounce counter is cleared by an evaluation, the periodic counter is cleared too, and the unit returns to periodic scanning.
- R7: A confirmed event ORs its hit set into the status vector (bit n = pair n) at the next clock edge. Hardware never clears a status bit. A 1 on the clear input clears that bit, unless the same edge sets it.
- R8: The interrupt output is high exactly when any status bit is set.
- R9: Both samples are captured on a confirmed event only if the status vector, after that cycle's clears, is empty. Otherwise the captured values hold.
- R10: The wakeup output for a pair is high for the one cycle after a confirmed event in which that pair hit and has its wakeup enable set. At all other times it is low.
- R11: A configuration-write pulse clears both counters and the previous hit set, and it overrides an evaluation in the same cycle. It does not change the status vector or the captured values.
- R12: An active-low asynchronous reset clears the counters, previous hit set, status, captured values and wakeup outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluate the presented samples this cycle |
| smp0_i | input | DATA_W | Channel 0 sample |
| smp1_i | input | DATA_W | Channel 1 sample |
| lo0_i | input | NUM_PAIRS*DATA_W | Channel 0 lower limits, pair n in slice n |
| hi0_i | input | NUM_PAIRS*DATA_W | Channel 0 upper limits |
| lo1_i | input | NUM_PAIRS*DATA_W | Channel 1 lower limits |
| hi1_i | input | NUM_PAIRS*DATA_W | Channel 1 upper limits |
| out0_i | input | NUM_PAIRS | Channel 0 mode per pair, 1 = outside |
| out1_i | input | NUM_PAIRS | Channel 1 mode per pair, 1 = outside |
| en0_i | input | NUM_PAIRS | Channel 0 window enable per pair |
| en1_i | input | NUM_PAIRS | Channel 1 window enable per pair |
| wake_en_i | input | NUM_PAIRS | Wakeup enable per pair |
| lp_en_i | input | 1 | Low-power periodic scanning enabled |
| lp_lim_i | input | CNT_W | Periodic counter limit |
| db_lim_i | input | CNT_W | Debounce threshold |
| cfg_wr_i | input | 1 | Configuration changed; clears tracking state |
| sts_clr_i | input | NUM_PAIRS | Write-one-to-clear for status bits |
| status_o | output | NUM_PAIRS | Sticky confirmed-hit status |
| irq_o | output | 1 | Interrupt, any status bit set |
| wake_o | output | NUM_PAIRS | One-cycle wakeup pulses |
| cont_req_o | output | 1 | Request continuous scanning |
| lat0_o | output | DATA_W | Captured channel 0 sample of first confirmed event |
| lat1_o | output | DATA_W | Captured channel 1 sample of first confirmed event |

## Verification
The bench builds the unit with 6-bit samples, four pairs and 3-bit counters. With 6-bit samples the all-ones upper limit (63) and both edges of every window can be tested directly. With 3-bit counters, small thresholds, saturation at threshold and the hand-over from periodic to debounce counting all occur within a few evaluations. A random phase changes limits, modes, enables, clears and configuration writes together. This drives set changes, empty sets and clear-versus-set collisions far more often than a realistic input would.

// File: rtl/winflt_pkg.sv
package winflt_pkg;
   typedef enum logic {
      WIN_INSIDE  = 1'b0,
      WIN_OUTSIDE = 1'b1
   } win_mode_e;

   localparam int unsigned DEF_DATA_W = 10;
   localparam int unsigned DEF_PAIRS  = 8;
   localparam int unsigned DEF_CNT_W  = 6;
endpackage

// File: rtl/winflt_window.sv
module winflt_window
   import winflt_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W
) (
   input  logic [DATA_W-1:0] smp_i,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   input  win_mode_e         mode_i,
   output logic              hit_o
);
   logic above_lo;
   logic below_hi;
   logic in_range;

   always_comb begin
      above_lo = (smp_i >= lo_i);
      below_hi = (smp_i <= hi_i);
      in_range = above_lo & below_hi;
      hit_o    = (mode_i == WIN_INSIDE) ? in_range : ~in_range;
   end
endmodule

// File: rtl/winflt_track.sv
module winflt_track
   import winflt_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = DEF_PAIRS,
   parameter int unsigned CNT_W     = DEF_CNT_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 eval_i,
   input  logic                 cfg_wr_i,
   input  logic [NUM_PAIRS-1:0] hits_i,
   input  logic                 lp_en_i,
   input  logic [CNT_W-1:0]     lp_lim_i,
   input  logic [CNT_W-1:0]     db_lim_i,
   output logic                 deb_o,
   output logic                 cont_req_o,
   output logic [CNT_W-1:0]     lp_cnt_o,
   output logic [CNT_W-1:0]     db_cnt_o
);
   logic [NUM_PAIRS-1:0] prev_q;
   logic [CNT_W-1:0]     lp_cnt_q;
   logic [CNT_W-1:0]     db_cnt_q;

   logic                 to_lp;
   logic                 keep;
   logic [CNT_W-1:0]     cur;
   logic [CNT_W-1:0]     lim;
   logic [CNT_W-1:0]     nxt;

   always_comb begin
      to_lp = lp_en_i && (lp_cnt_q < lp_lim_i);
      keep  = (hits_i != '0) && ((prev_q == '0) || (prev_q == hits_i));
      cur   = to_lp ? lp_cnt_q : db_cnt_q;
      lim   = to_lp ? lp_lim_i : db_lim_i;
      if (!keep) begin
         nxt = '0;
      end else if (cur < lim) begin
         nxt = cur + 1'b1;
      end else begin
         nxt = cur;
      end
      deb_o = eval_i && !cfg_wr_i && !to_lp && keep && (nxt == db_lim_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q   <= '0;
         lp_cnt_q <= '0;
         db_cnt_q <= '0;
      end else if (cfg_wr_i) begin
         prev_q   <= '0;
         lp_cnt_q <= '0;
         db_cnt_q <= '0;
      end else if (eval_i) begin
         prev_q <= hits_i;
         if (to_lp) begin
            lp_cnt_q <= nxt;
         end else begin
            db_cnt_q <= nxt;
            if (!keep) begin
               lp_cnt_q <= '0;
            end
         end
      end
   end

   assign cont_req_o = lp_en_i && (lp_cnt_q >= lp_lim_i);
   assign lp_cnt_o   = lp_cnt_q;
   assign db_cnt_o   = db_cnt_q;
endmodule

// File: rtl/winflt_report.sv
module winflt_report
   import winflt_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = DEF_PAIRS,
   parameter int unsigned DATA_W    = DEF_DATA_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 deb_i,
   input  logic [NUM_PAIRS-1:0] hits_i,
   input  logic [NUM_PAIRS-1:0] wake_en_i,
   input  logic [NUM_PAIRS-1:0] clr_i,
   input  logic [DATA_W-1:0]    smp0_i,
   input  logic [DATA_W-1:0]    smp1_i,
   output logic [NUM_PAIRS-1:0] status_o,
   output logic [NUM_PAIRS-1:0] wake_o,
   output logic [DATA_W-1:0]    lat0_o,
   output logic [DATA_W-1:0]    lat1_o
);
   logic [NUM_PAIRS-1:0] status_q;
   logic [NUM_PAIRS-1:0] kept;
   logic                 first_evt;

   always_comb begin
      kept      = status_q & ~clr_i;
      first_evt = deb_i && (kept == '0);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q <= '0;
         wake_o   <= '0;
      end else begin
         status_q <= deb_i ? (kept | hits_i) : kept;
         wake_o   <= deb_i ? (hits_i & wake_en_i) : '0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lat0_o <= '0;
         lat1_o <= '0;
      end else if (first_evt) begin
         lat0_o <= smp0_i;
         lat1_o <= smp1_i;
      end
   end

   assign status_o = status_q;
endmodule

// File: rtl/winflt_debounce.sv
module winflt_debounce
   import winflt_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = DEF_PAIRS,
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned CNT_W     = DEF_CNT_W
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        eval_i,
   input  logic [DATA_W-1:0]           smp0_i,
   input  logic [DATA_W-1:0]           smp1_i,
   input  logic [NUM_PAIRS*DATA_W-1:0] lo0_i,
   input  logic [NUM_PAIRS*DATA_W-1:0] hi0_i,
   input  logic [NUM_PAIRS*DATA_W-1:0] lo1_i,
   input  logic [NUM_PAIRS*DATA_W-1:0] hi1_i,
   input  logic [NUM_PAIRS-1:0]        out0_i,
   input  logic [NUM_PAIRS-1:0]        out1_i,
   input  logic [NUM_PAIRS-1:0]        en0_i,
   input  logic [NUM_PAIRS-1:0]        en1_i,
   input  logic [NUM_PAIRS-1:0]        wake_en_i,
   input  logic                        lp_en_i,
   input  logic [CNT_W-1:0]            lp_lim_i,
   input  logic [CNT_W-1:0]            db_lim_i,
   input  logic                        cfg_wr_i,
   input  logic [NUM_PAIRS-1:0]        sts_clr_i,
   output logic [NUM_PAIRS-1:0]        status_o,
   output logic                        irq_o,
   output logic [NUM_PAIRS-1:0]        wake_o,
   output logic                        cont_req_o,
   output logic [DATA_W-1:0]           lat0_o,
   output logic [DATA_W-1:0]           lat1_o
);
   localparam int unsigned SPAN_W = NUM_PAIRS * DATA_W;

   if (NUM_PAIRS < 1 || NUM_PAIRS > 32) begin : g_bad_pairs
      $error("winflt_debounce: NUM_PAIRS must be 1..32");
   end
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data
      $error("winflt_debounce: DATA_W must be 2..16");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("winflt_debounce: CNT_W must be 1..16");
   end
   if (SPAN_W != $bits(lo0_i)) begin : g_bad_span
      $error("winflt_debounce: limit bus width mismatch");
   end

   logic [NUM_PAIRS-1:0] ch0_hit;
   logic [NUM_PAIRS-1:0] ch1_hit;
   logic [NUM_PAIRS-1:0] pair_hit;
   logic                 deb;
   logic [CNT_W-1:0]     lp_cnt;
   logic [CNT_W-1:0]     db_cnt;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      winflt_window #(.DATA_W(DATA_W)) u_win0 (
         .smp_i  (smp0_i),
         .lo_i   (lo0_i[p*DATA_W +: DATA_W]),
         .hi_i   (hi0_i[p*DATA_W +: DATA_W]),
         .mode_i (win_mode_e'(out0_i[p])),
         .hit_o  (ch0_hit[p])
      );
      winflt_window #(.DATA_W(DATA_W)) u_win1 (
         .smp_i  (smp1_i),
         .lo_i   (lo1_i[p*DATA_W +: DATA_W]),
         .hi_i   (hi1_i[p*DATA_W +: DATA_W]),
         .mode_i (win_mode_e'(out1_i[p])),
         .hit_o  (ch1_hit[p])
      );
      assign pair_hit[p] = (en0_i[p] | en1_i[p])
                         & (ch0_hit[p] | ~en0_i[p])
                         & (ch1_hit[p] | ~en1_i[p]);
   end

   winflt_track #(.NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W)) u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .eval_i     (eval_i),
      .cfg_wr_i   (cfg_wr_i),
      .hits_i     (pair_hit),
      .lp_en_i    (lp_en_i),
      .lp_lim_i   (lp_lim_i),
      .db_lim_i   (db_lim_i),
      .deb_o      (deb),
      .cont_req_o (cont_req_o),
      .lp_cnt_o   (lp_cnt),
      .db_cnt_o   (db_cnt)
   );

   winflt_report #(.NUM_PAIRS(NUM_PAIRS), .DATA_W(DATA_W)) u_rep (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .deb_i     (deb),
      .hits_i    (pair_hit),
      .wake_en_i (wake_en_i),
      .clr_i     (sts_clr_i),
      .smp0_i    (smp0_i),
      .smp1_i    (smp1_i),
      .status_o  (status_o),
      .wake_o    (wake_o),
      .lat0_o    (lat0_o),
      .lat1_o    (lat1_o)
   );

   assign irq_o = |status_o;
endmodule

// File: rtl/winflt_debounce_chk.sv
module winflt_debounce_chk #(
   parameter int unsigned NUM_PAIRS = 8,
   parameter int unsigned DATA_W    = 10,
   parameter int unsigned CNT_W     = 6
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 eval_i,
   input logic                 cfg_wr_i,
   input logic                 lp_en_i,
   input logic [NUM_PAIRS-1:0] sts_clr_i,
   input logic [NUM_PAIRS-1:0] pair_hit,
   input logic                 deb,
   input logic [CNT_W-1:0]     lp_cnt,
   input logic [CNT_W-1:0]     db_cnt,
   input logic [NUM_PAIRS-1:0] status_o,
   input logic [NUM_PAIRS-1:0] wake_o,
   input logic [DATA_W-1:0]    lat0_o,
   input logic [DATA_W-1:0]    lat1_o
);
   assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_o & ~sts_clr_i) != '0) |=>
      ((status_o & $past(status_o & ~sts_clr_i)) == $past(status_o & ~sts_clr_i)));

   assert_confirm_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deb |=> ((status_o & $past(pair_hit)) == $past(pair_hit)));

   assert_capture_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_o & ~sts_clr_i) != '0) |=> ($stable(lat0_o) && $stable(lat1_o)));

   assert_wake_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eval_i |=> (wake_o == '0));

   assert_cfg_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_wr_i |=> (lp_cnt == '0 && db_cnt == '0));

   assert_empty_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && !cfg_wr_i && !lp_en_i && pair_hit == '0) |=> (db_cnt == '0));
endmodule

bind winflt_debounce winflt_debounce_chk #(
   .NUM_PAIRS (NUM_PAIRS),
   .DATA_W    (DATA_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .eval_i    (eval_i),
   .cfg_wr_i  (cfg_wr_i),
   .lp_en_i   (lp_en_i),
   .sts_clr_i (sts_clr_i),
   .pair_hit  (pair_hit),
   .deb       (deb),
   .lp_cnt    (lp_cnt),
   .db_cnt    (db_cnt),
   .status_o  (status_o),
   .wake_o    (wake_o),
   .lat0_o    (lat0_o),
   .lat1_o    (lat1_o)
);

// File: tb/winflt_debounce_tb.sv
module winflt_debounce_tb;
   localparam int NP     = 4;
   localparam int DW     = 6;
   localparam int CW     = 3;
   localparam int CLK_NS = 10;
   localparam int VMAX   = (1 << DW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   int  cfg_lo0[NP], cfg_hi0[NP], cfg_lo1[NP], cfg_hi1[NP];
   bit  cfg_out0[NP], cfg_out1[NP], cfg_en0[NP], cfg_en1[NP];
   int  wake_en, clr, s0, s1, lp_lim, db_lim;
   bit  lp_en, eval, cfg_wr;

   logic [NP*DW-1:0] lo0_v, hi0_v, lo1_v, hi1_v;
   logic [NP-1:0]    out0_v, out1_v, en0_v, en1_v;

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         lo0_v[p*DW +: DW] = DW'(cfg_lo0[p]);
         hi0_v[p*DW +: DW] = DW'(cfg_hi0[p]);
         lo1_v[p*DW +: DW] = DW'(cfg_lo1[p]);
         hi1_v[p*DW +: DW] = DW'(cfg_hi1[p]);
         out0_v[p] = cfg_out0[p];
         out1_v[p] = cfg_out1[p];
         en0_v[p]  = cfg_en0[p];
         en1_v[p]  = cfg_en1[p];
      end
   end

   logic [NP-1:0] status_o, wake_o;
   logic          irq_o, cont_req_o;
   logic [DW-1:0] lat0_o, lat1_o;

   winflt_debounce #(.NUM_PAIRS(NP), .DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .eval_i(eval),
      .smp0_i(DW'(s0)), .smp1_i(DW'(s1)),
      .lo0_i(lo0_v), .hi0_i(hi0_v), .lo1_i(lo1_v), .hi1_i(hi1_v),
      .out0_i(out0_v), .out1_i(out1_v), .en0_i(en0_v), .en1_i(en1_v),
      .wake_en_i(NP'(wake_en)), .lp_en_i(lp_en),
      .lp_lim_i(CW'(lp_lim)), .db_lim_i(CW'(db_lim)),
      .cfg_wr_i(cfg_wr), .sts_clr_i(NP'(clr)),
      .status_o(status_o), .irq_o(irq_o), .wake_o(wake_o),
      .cont_req_o(cont_req_o), .lat0_o(lat0_o), .lat1_o(lat1_o)
   );

   // behavioural reference state
   int m_prev, m_lp, m_db, m_sts, m_lat0, m_lat1, m_wake;
   int n_prev, n_lp, n_db, n_sts, n_lat0, n_lat1, n_wake;
   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_hits(int v0, int v1);
      int r = 0;
      for (int p = 0; p < NP; p++) begin
         bit a0, a1;
         a0 = cfg_out0[p] ? (v0 < cfg_lo0[p] || v0 > cfg_hi0[p])
                          : (v0 >= cfg_lo0[p] && v0 <= cfg_hi0[p]);
         a1 = cfg_out1[p] ? (v1 < cfg_lo1[p] || v1 > cfg_hi1[p])
                          : (v1 >= cfg_lo1[p] && v1 <= cfg_hi1[p]);
         if ((cfg_en0[p] || cfg_en1[p]) && (!cfg_en0[p] || a0) && (!cfg_en1[p] || a1))
            r |= (1 << p);
      end
      return r;
   endfunction

   task automatic model_clear();
      m_prev = 0; m_lp = 0; m_db = 0; m_sts = 0; m_lat0 = 0; m_lat1 = 0; m_wake = 0;
   endtask

   task automatic model_step();
      int hits;
      bit to_lp, keep, deb;
      int cur, lim, nc;
      hits = model_hits(s0, s1);
      n_prev = m_prev; n_lp = m_lp; n_db = m_db;
      n_sts = m_sts & ~clr; n_lat0 = m_lat0; n_lat1 = m_lat1; n_wake = 0;
      deb = 0;
      if (cfg_wr) begin
         n_prev = 0; n_lp = 0; n_db = 0;
      end else if (eval) begin
         to_lp = lp_en && (m_lp < lp_lim);
         keep = (hits != 0) && (m_prev == 0 || m_prev == hits);
         cur = to_lp ? m_lp : m_db;
         lim = to_lp ? lp_lim : db_lim;
         nc = !keep ? 0 : (cur < lim ? cur + 1 : cur);
         if (to_lp) n_lp = nc;
         else begin
            n_db = nc;
            if (!keep) n_lp = 0;
            deb = keep && (nc == db_lim);
         end
         n_prev = hits;
      end
      if (deb) begin
         if (n_sts == 0) begin n_lat0 = s0; n_lat1 = s1; end
         n_sts |= hits;
         n_wake = hits & wake_en;
      end
   endtask

   task automatic compare_all();
      check("R7 status", int'(status_o), m_sts);
      check("R8 irq", int'(irq_o), int'(m_sts != 0));
      check("R10 wake", int'(wake_o), m_wake);
      check("R5 cont_req", int'(cont_req_o), int'(lp_en && m_lp >= lp_lim));
      check("R9 lat0", int'(lat0_o), m_lat0);
      check("R9 lat1", int'(lat1_o), m_lat1);
   endtask

   // one clock: predict, clock, commit, compare at the falling edge
   task automatic tick();
      model_step();
      @(posedge clk);
      #1;
      m_prev = n_prev; m_lp = n_lp; m_db = n_db; m_sts = n_sts;
      m_lat0 = n_lat0; m_lat1 = n_lat1; m_wake = n_wake;
      @(negedge clk);
      compare_all();
      eval = 0; cfg_wr = 0; clr = 0;
   endtask

   task automatic set_win(int p, int ch, int lo, int hi, bit outside, bit en);
      if (ch == 0) begin
         cfg_lo0[p] = lo; cfg_hi0[p] = hi; cfg_out0[p] = outside; cfg_en0[p] = en;
      end else begin
         cfg_lo1[p] = lo; cfg_hi1[p] = hi; cfg_out1[p] = outside; cfg_en1[p] = en;
      end
   endtask

   task automatic do_eval(int v0, int v1);
      s0 = v0; s1 = v1; eval = 1; tick();
   endtask

   task automatic do_cfg();
      cfg_wr = 1; tick();
   endtask

   task automatic do_clr(int m);
      clr = m; tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) begin
         set_win(p, 0, 0, VMAX, 0, 0);
         set_win(p, 1, 0, VMAX, 0, 0);
      end
      wake_en = '1; clr = 0; s0 = 0; s1 = 0; lp_lim = 0; db_lim = 0;
      lp_en = 0; eval = 0; cfg_wr = 0;
      model_clear();
      repeat (3) @(negedge clk);
      // R12: reset state at the ports
      check("R12 status", int'(status_o), 0);
      check("R12 wake", int'(wake_o), 0);
      check("R12 lat0", int'(lat0_o), 0);
      rst_n = 1;
      @(negedge clk);

      // R1/R2: window edges, observed through wake with threshold 0
      set_win(0, 0, 7, 23, 0, 1);   set_win(0, 1, 0, VMAX, 0, 1);
      set_win(1, 0, 7, 23, 1, 1);   set_win(1, 1, 0, VMAX, 0, 1);
      set_win(2, 0, 0, VMAX, 0, 1);
      do_cfg(); do_eval(6, 30);  check("R1 below lower", int'(wake_o), 4'b0110);
      do_cfg(); do_eval(7, 30);  check("R1 lower edge", int'(wake_o), 4'b0101);
      do_cfg(); do_eval(23, 30); check("R1 upper edge", int'(wake_o), 4'b0101);
      do_cfg(); do_eval(24, 30); check("R1 above upper", int'(wake_o), 4'b0110);
      set_win(2, 1, 0, VMAX, 1, 1);
      do_cfg(); do_eval(7, 30);  check("R2 outside all blocks pair", int'(wake_o), 4'b0001);
      check("R2 disabled pair3 never set", int'(status_o[3]), 0);

      // R3/R4/R7/R9: debounce threshold 3 on pairs 0 and 1
      set_win(0, 0, 10, 20, 0, 1); set_win(0, 1, 0, VMAX, 0, 1);
      set_win(1, 0, 15, 30, 0, 1); set_win(1, 1, 0, VMAX, 0, 1);
      set_win(2, 0, 0, VMAX, 0, 0); set_win(2, 1, 0, VMAX, 0, 0);
      db_lim = 3;
      do_cfg(); do_clr(4'b1111);
      check("R8 irq low after clear", int'(irq_o), 0);
      do_eval(15, 40); check("R3 count1 no event", int'(wake_o), 0);
      do_eval(15, 40); check("R3 count2 no event", int'(wake_o), 0);
      do_eval(15, 40); check("R3 threshold event", int'(wake_o), 4'b0011);
      check("R9 first capture ch0", int'(lat0_o), 15);
      check("R9 first capture ch1", int'(lat1_o), 40);
      do_eval(15, 41); check("R3 saturated repeat", int'(wake_o), 4'b0011);
      check("R9 capture holds", int'(lat1_o), 40);
      do_eval(25, 41); check("R4 changed set clears", int'(wake_o), 0);
      do_eval(25, 41); do_eval(25, 41);
      check("R4 restarted count below", int'(wake_o), 0);
      do_eval(25, 41); check("R3 new set confirms", int'(wake_o), 4'b0010);
      do_eval(0, 41);  check("R4 empty set", int'(wake_o), 0);
      do_eval(25, 41); check("R4 count from zero", int'(wake_o), 0);
      do_clr(4'b0001); check("R7 w1c one bit", int'(status_o), 4'b0010);
      check("R8 irq still high", int'(irq_o), 1);
      do_clr(4'b0010); check("R8 irq low", int'(irq_o), 0);
      do_eval(25, 9); do_eval(25, 9);
      check("R9 recapture after clear", int'(lat0_o), 25);
      check("R9 recapture ch1", int'(lat1_o), 9);

      // R5/R6/R10/R11: periodic counter hand-over
      lp_en = 1; lp_lim = 2; db_lim = 2;
      do_cfg(); do_clr(4'b1111);
      do_eval(15, 5); check("R5 periodic count1", int'(cont_req_o), 0);
      do_eval(15, 5); check("R5 continuous request", int'(cont_req_o), 1);
      check("R5 no event on periodic path", int'(wake_o), 0);
      do_eval(15, 5);
      wake_en = 4'b0001;
      do_eval(15, 5); check("R10 wake masked", int'(wake_o), 4'b0001);
      tick();         check("R10 wake one cycle", int'(wake_o), 0);
      do_eval(0, 5);  check("R6 back to periodic", int'(cont_req_o), 0);
      do_eval(15, 5); do_eval(15, 5);
      check("R5 request again", int'(cont_req_o), 1);
      do_cfg();       check("R11 config clears", int'(cont_req_o), 0);
      check("R11 status kept", int'(status_o), 4'b0011);

      // mixed random phase against the reference model
      wake_en = '1;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 19) == 0) begin
            for (int p = 0; p < NP; p++) begin
               int a, b;
               a = $urandom_range(0, VMAX); b = $urandom_range(0, VMAX);
               set_win(p, 0, (a < b) ? a : b, (a < b) ? b : a,
                       $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);
               set_win(p, 1, 0, $urandom_range(VMAX/2, VMAX),
                       $urandom_range(0, 7) == 0, $urandom_range(0, 1));
            end
            lp_en = $urandom_range(0, 1);
            lp_lim = $urandom_range(0, 3);
            db_lim = $urandom_range(0, 4);
            wake_en = $urandom_range(0, (1 << NP) - 1);
            cfg_wr = 1;
         end
         if ($urandom_range(0, 7) == 0) clr = $urandom_range(0, (1 << NP) - 1);
         eval = $urandom_range(0, 1);
         s0 = ($urandom_range(0, 3) == 0) ? $urandom_range(0, VMAX) : 15 + $urandom_range(0, 2);
         s1 = $urandom_range(0, VMAX);
         tick();
      end

      // R12: asynchronous reset mid-run
      rst_n = 0;
      #1;
      model_clear();
      check("R12 async status", int'(status_o), 0);
      check("R12 async lat1", int'(lat1_o), 0);
      @(negedge clk);
      rst_n = 1;
      lp_en = 0;
      tick();

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule